// File: doc/BRIEF.md
# Tile-Map Video RAM Address Generator

This block forms the video-side address into a 4K-word video RAM for a tile-based raster display. Each video memory access is split into a CPU half and a video half by the 2H bit of the horizontal counter. In the video half the block turns the raster position into an address. It uses one of three mappings: the ordinary 8x8 tile playfield, a reshuffled mapping for the score and status rows at the sides of the picture, and a short sprite-attribute table that is read during vertical blanking. In the CPU half it releases the bus.

The raster counters come from outside the block as plain bit vectors. The address and its valid flag leave the block through a register, so they always trail the counter values by one clock. The address stream has no ready input and cannot be held back. Video timing cannot stall, so a consumer must accept every address in the cycle it is marked valid.

Top module: `tile_vram_addr_gen`

## Requirements
- R1: While `rst_n` is low, `vid_valid` is 0 and `vid_addr` is 0, whatever the counters hold.
- R2: The outputs are registered and reflect the inputs of the previous clock. When hcnt[1] (2H) was 0, `vid_valid` is 0 and `vid_addr` is 0 so that the CPU owns the bus.
- R3: Outside blanking, with hcnt[1]=1 and hcnt[8] (256H)=0, `vid_valid` is 1 and vid_addr[9:0] = {vcnt[7:3], hcnt[7:3]}, with bit 9 the most significant.
- R4: In that playfield mode, vid_addr[10] equals hcnt[2] (4H), so tile code and colour are read in consecutive 4H phases, and vid_addr[11] is 0.
- R5: hcnt[0], vcnt[2:0] and, in the video half, hcnt[1] never change the address value.
- R6: Outside blanking, with hcnt[1]=1, hcnt[8]=1 and hcnt[4]=hcnt[5]=hcnt[6], `vid_valid` is 1 and vid_addr = {0, hcnt[2], hcnt[6] repeated four times, hcnt[3], vcnt[7:3]} from bit 11 down.
- R7: Outside blanking, with hcnt[1]=1, hcnt[8]=1 and hcnt[4], hcnt[5], hcnt[6] not all equal, `vid_valid` is 0 and `vid_addr` is 0.
- R8: During vblank with hcnt[1]=1, `vid_valid` is 1 and vid_addr = 0xFF2 + k. Here k counts the completed 2H-high slots since blanking began, and a slot completes on a cycle where hcnt[1:0]=3.
- R9: The sprite offset stops at 0xFFD after twelve entries (six sprites of two words each) and stays there for the rest of blanking.
- R10: Vblank takes priority over the 256H mode select, and that select takes priority over the playfield mapping. When vblank falls, the sprite offset returns to 0xFF2 for the next blanking period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcnt | input | 9 | Horizontal counter, bit 0 = 1H up to bit 8 = 256H |
| vcnt | input | 8 | Vertical counter, bit 0 = 1V up to bit 7 = 128V |
| vblank | input | 1 | Vertical blanking flag |
| vid_addr | output | 12 | Registered video RAM address, 0 when not valid |
| vid_valid | output | 1 | Address is valid for the video half of the access |

## Verification
The embedded properties check the following on every cycle:
- the CPU half always releases the bus;
- playfield addresses keep bit 11 clear and bit 10 tied to 4H;
- border addresses repeat 64H across bits 9 to 6;
- every blanking address falls inside the sprite window;
- the sprite offset saturates at its last entry and restarts once blanking ends.

Only the bench's sweeps show the exact bit placement of each mapping and the one-per-slot stepping order. Those sweeps run over all horizontal positions and over every tile row, with the unused low counter bits varied. The bench also shows that reset dominates the counters.

// File: rtl/vram_agen_pkg.sv
package vram_agen_pkg;
  typedef enum logic [1:0] {
    FM_IDLE   = 2'd0,
    FM_FIELD  = 2'd1,
    FM_BORDER = 2'd2,
    FM_SPRITE = 2'd3
  } fetch_mode_e;
endpackage

// File: rtl/vag_mode_dec.sv
module vag_mode_dec
  import vram_agen_pkg::*;
#(
  parameter int HW = 9
) (
  input  logic [HW-1:0] hcnt,
  input  logic          vblank,
  output fetch_mode_e   mode
);
  logic border_match;
  assign border_match = (hcnt[4] == hcnt[5]) && (hcnt[5] == hcnt[6]);

  always_comb begin
    if (!hcnt[1])              mode = FM_IDLE;
    else if (vblank)           mode = FM_SPRITE;
    else if (hcnt[HW-1])       mode = border_match ? FM_BORDER : FM_IDLE;
    else                       mode = FM_FIELD;
  end
endmodule

// File: rtl/vag_sprite_ctr.sv
module vag_sprite_ctr #(
  parameter int SPR_COUNT = 12,
  localparam int IDXW = $clog2(SPR_COUNT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vblank,
  input  logic            slot_end,
  output logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(SPR_COUNT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idx <= '0;
    else if (!vblank)                idx <= '0;
    else if (slot_end && idx != LAST) idx <= idx + 1'b1;
  end

  AST_SPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && idx == LAST) |=> (idx == LAST)); // R9
  AST_SPR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!vblank) |=> (idx == '0)); // R10
  AST_SPR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (idx <= LAST)); // R9
endmodule

// File: rtl/vag_addr_map.sv
module vag_addr_map
  import vram_agen_pkg::*;
#(
  parameter int HW = 9,
  parameter int VW = 8,
  parameter int AW = 12,
  parameter int SPR_COUNT = 12,
  parameter logic [AW-1:0] SPR_BASE = 12'hFF2,
  localparam int IDXW = $clog2(SPR_COUNT),
  localparam int TILE_SH = 3,
  localparam int ROWB = VW - TILE_SH,
  localparam int COLB = HW - 1 - TILE_SH,
  localparam int REP = AW - 2 - 1 - ROWB
) (
  input  fetch_mode_e     mode,
  input  logic [HW-1:0]   hcnt,
  input  logic [VW-1:0]   vcnt,
  input  logic [IDXW-1:0] idx,
  output logic [AW-1:0]   addr,
  output logic            valid
);
  logic [ROWB-1:0] row;
  logic [COLB-1:0] col;
  logic [AW-1:0]   field_a, border_a, sprite_a;

  assign row = vcnt[VW-1:TILE_SH];
  assign col = hcnt[HW-2:TILE_SH];

  assign field_a  = {1'b0, hcnt[2], row, col};
  assign border_a = {1'b0, hcnt[2], {REP{hcnt[6]}}, hcnt[3], row};
  assign sprite_a = SPR_BASE + AW'(idx);

  always_comb begin
    unique case (mode)
      FM_FIELD:  begin addr = field_a;  valid = 1'b1; end
      FM_BORDER: begin addr = border_a; valid = 1'b1; end
      FM_SPRITE: begin addr = sprite_a; valid = 1'b1; end
      default:   begin addr = '0;       valid = 1'b0; end
    endcase
  end
endmodule

// File: rtl/tile_vram_addr_gen.sv
module tile_vram_addr_gen
  import vram_agen_pkg::*;
#(
  parameter int HW = 9,
  parameter int VW = 8,
  parameter int AW = 12,
  parameter int SPR_COUNT = 12,
  parameter logic [AW-1:0] SPR_BASE = 12'hFF2,
  localparam int IDXW = $clog2(SPR_COUNT),
  localparam logic [AW-1:0] SPR_LAST = SPR_BASE + AW'(SPR_COUNT - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          vblank,
  output logic [AW-1:0] vid_addr,
  output logic          vid_valid
);
  fetch_mode_e     mode;
  logic [IDXW-1:0] spr_idx;
  logic [AW-1:0]   nxt_addr;
  logic            nxt_valid;

  vag_mode_dec #(.HW(HW)) u_mode (
    .hcnt(hcnt), .vblank(vblank), .mode(mode)
  );

  vag_sprite_ctr #(.SPR_COUNT(SPR_COUNT)) u_spr (
    .clk(clk), .rst_n(rst_n), .vblank(vblank),
    .slot_end(hcnt[1] & hcnt[0]), .idx(spr_idx)
  );

  vag_addr_map #(.HW(HW), .VW(VW), .AW(AW), .SPR_COUNT(SPR_COUNT),
                 .SPR_BASE(SPR_BASE)) u_map (
    .mode(mode), .hcnt(hcnt), .vcnt(vcnt), .idx(spr_idx),
    .addr(nxt_addr), .valid(nxt_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_addr  <= '0;
      vid_valid <= 1'b0;
    end else begin
      vid_addr  <= nxt_addr;
      vid_valid <= nxt_valid;
    end
  end

  AST_CPU_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hcnt[1]) |=> (!vid_valid && vid_addr == '0)); // R2
  AST_FIELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt[1] && !vblank && !hcnt[HW-1]) |=>
      (vid_valid && !vid_addr[AW-1] && vid_addr[AW-2] == $past(hcnt[2]))); // R4
  AST_BORDER_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt[1] && !vblank && hcnt[HW-1]) |=>
      (!vid_valid || $countones(vid_addr[9:6]) == 0 || $countones(vid_addr[9:6]) == 4)); // R6
  AST_VB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt[1] && vblank) |=>
      (vid_valid && vid_addr >= SPR_BASE && vid_addr <= SPR_LAST)); // R8
endmodule

// File: tb/tile_vram_addr_gen_test.sv
`timescale 1ns/1ps
module tile_vram_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  hcnt = 9'd3;
  logic [7:0]  vcnt = 8'hFF;
  logic        vblank = 1'b1;
  logic [11:0] vid_addr;
  logic        vid_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [11:0] exp_addr;
  logic        exp_valid;
  string       exp_tag;
  bit          have_exp = 0;
  int          m_idx = 0;

  always #5 clk = ~clk;

  tile_vram_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .vblank(vblank),
    .vid_addr(vid_addr), .vid_valid(vid_valid)
  );

  task automatic check(input string tag, input logic [11:0] ea, input logic ev);
    checks++;
    if (vid_addr !== ea || vid_valid !== ev) begin
      errors++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b (h=%h v=%h vb=%b)",
               tag, vid_addr, vid_valid, ea, ev, hcnt, vcnt, vblank);
    end
  endtask

  task automatic step(input logic [8:0] h, input logic [7:0] v, input logic vb);
    @(negedge clk);
    if (have_exp) check(exp_tag, exp_addr, exp_valid);
    hcnt = h; vcnt = v; vblank = vb;
    if (!h[1]) begin
      exp_addr = 12'h000; exp_valid = 1'b0; exp_tag = "R2";
    end else if (vb) begin
      exp_addr = 12'hFF2 + 12'(m_idx); exp_valid = 1'b1;
      exp_tag = (m_idx == 11) ? "R9" : (h[8] ? "R10" : "R8");
    end else if (h[8]) begin
      if (h[4] == h[5] && h[5] == h[6]) begin
        exp_addr = {1'b0, h[2], {4{h[6]}}, h[3], v[7:3]}; exp_valid = 1'b1; exp_tag = "R6";
      end else begin
        exp_addr = 12'h000; exp_valid = 1'b0; exp_tag = "R7";
      end
    end else begin
      exp_addr = {1'b0, h[2], v[7:3], h[7:3]}; exp_valid = 1'b1; exp_tag = "R3 R4 R5";
    end
    if (!vb) m_idx = 0;
    else if (h[1] && h[0] && m_idx < 11) m_idx++;
    have_exp = 1;
  endtask

  initial begin
    // R1: reset dominates a counter state that would otherwise be valid
    repeat (3) begin
      @(negedge clk);
      check("R1", 12'h000, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // playfield and border sweep over every tile row, low bits varied (R5)
    for (int r = 0; r < 32; r++) begin
      for (int h = 0; h < 512; h++) begin
        logic [2:0] lo;
        lo = 3'(r) ^ 3'(h >> 6);
        step(9'(h), {5'(r), lo}, 1'b0);
      end
    end
    // blanking: sprite window stepping, saturation across two lines
    for (int ln = 0; ln < 2; ln++)
      for (int h = 0; h < 512; h++)
        step(9'(h), 8'(224 + ln), 1'b1);
    // R10: leave blanking, then restart the window
    for (int h = 0; h < 16; h++) step(9'(h), 8'd16, 1'b0);
    for (int h = 256; h < 320; h++) step(9'(h), 8'd240, 1'b1);
    step(9'd0, 8'd0, 1'b0);
    step(9'd0, 8'd0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule